// File: doc/BRIEF.md
# Byte-Wide Host Port Bridge

This block is the slave side of a host port. It sits between an 8-bit bus master and a processor core with a 24-bit word. The host sees eight byte registers selected by a 3-bit offset. Through them it can pass 24-bit words to the core and collect 24-bit words from the core. It can read a small status byte, keep one byte of interrupt-vector storage, and raise a vectored command request that the core services as an exception.

Host-to-core traffic is built one byte at a time. The upper and middle bytes are staged. A write of the low byte sends the assembled word into the core's receive buffer. Core-to-host traffic goes the other way: the core loads a full word, and the host reads it back byte by byte. Reading the low byte marks the word as consumed.

A single write to the command-vector register does two things when its top bit is set: it arms a request and selects the exception address, which is twice the vector number. A bit in the control register flushes both data paths in one stroke.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the status byte reads 0x02, the command-vector register reads 0x12, the interrupt-vector register reads 0x0F and the control register reads 0x00. `cmd_req` and `core_rx_valid` are low and `core_tx_ready` is high.
- R2: Offset 4 always reads 0x00. A write to offset 4 changes no register and no output.
- R3: Writes to offsets 5 and 6 stage the high and middle bytes. A write to offset 7 while the receive buffer is empty puts {high, middle, written byte} on `core_rx_word` and raises `core_rx_valid` after that clock edge. Staged bytes are kept after a commit, so a later write of the low byte alone reuses them.
- R4: Status bit 1 (host may write) is 0 while `core_rx_valid` is high. It returns to 1 one cycle after `core_rx_take`. A write to offset 7 while the buffer is full is dropped and `core_rx_word` keeps its value.
- R5: `core_tx_load` while `core_tx_ready` is high captures `core_tx_word`. It sets status bit 0 (word waiting for host) and drops `core_tx_ready`. A load while `core_tx_ready` is low is ignored.
- R6: Reads of offsets 5, 6 and 7 return bits 23:16, 15:8 and 7:0 of the core's word. A read strobe on offset 7 clears status bit 0 at that edge. Read strobes on offsets 5 and 6 do not clear it.
- R7: A write to offset 1 with bit 7 set raises `cmd_req` after that edge. At the same time `cmd_vector_addr` shows twice the vector held in bits 6:0.
- R8: `cmd_req` stays high until `cmd_ack` and is low the cycle after it. While it is high, writes to offset 1 are ignored and the readback stays the same.
- R9: A write to offset 1 with bit 7 clear replaces the vector and does not raise `cmd_req`. Offset 1 reads back {request bit, vector}.
- R10: Status bit 2 equals `cmd_req`, and status bits 7:3 read 0.
- R11: Writing offset 0 with bit 7 set makes offset 0 read 0x80 for exactly one cycle. At the next edge the bridge empties both data buffers, clears the staged bytes, zeroes both words and returns the bit to 0. The command request is left untouched.
- R12: Offset 3 is plain 8-bit read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, used for read side effects |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current offset, combinational |
| core_rx_word | output | 24 | Word passed from host to core |
| core_rx_valid | output | 1 | Receive buffer holds a word for the core |
| core_rx_take | input | 1 | Core consumes the receive word |
| core_tx_word | input | 24 | Word the core sends to the host |
| core_tx_load | input | 1 | Core loads `core_tx_word` |
| core_tx_ready | output | 1 | Transmit buffer empty, core may load |
| cmd_req | output | 1 | Vectored command request to the core |
| cmd_vector_addr | output | 8 | Exception address, twice the vector |
| cmd_ack | input | 1 | Core acknowledges the command request |

## Verification
Read data is combinational, so offset values are due in the same cycle the offset is set. Every register effect of a write, a read strobe, a load, a take or an acknowledge is due after the one clock edge that samples the strobe. The single exception is the control flush, which appears one edge later than the control readback.

The bench drives every strobe from the falling edge and holds it across exactly one rising edge. It samples at the next falling edge, or 1 ns after setting the offset for combinational readback, so each check lands in the cycle its result is due.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

    // Number of byte lanes in a transfer word; the register map fixes it at three.
    localparam int DATA_BYTES = 3;
    localparam int WORD_W     = 8 * DATA_BYTES;
    localparam int OFS_W      = 3;

    // Bit positions that carry behaviour.
    localparam int CTRL_FLUSH_BIT = 7;
    localparam int CVR_REQ_BIT    = 7;

    typedef enum logic [OFS_W-1:0] {
        RS_CTRL = 3'd0,
        RS_CVR  = 3'd1,
        RS_STAT = 3'd2,
        RS_IVR  = 3'd3,
        RS_NONE = 3'd4,
        RS_DHI  = 3'd5,
        RS_DMID = 3'd6,
        RS_DLO  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic                  ctrl;
        logic                  cvr;
        logic                  ivr;
        logic [DATA_BYTES-1:0] lane;   // lane 0 = low byte (commits)
    } wr_strobe_t;

    typedef struct packed {
        logic cmd_busy;
        logic tx_empty;
        logic rx_full;
    } status_t;

    function automatic logic [7:0] status_byte(input status_t s);
        return {5'b0, s};
    endfunction

    function automatic logic [7:0] lane_of(input logic [WORD_W-1:0] w, input int unsigned k);
        return w[8*k +: 8];
    endfunction

    // Offset of the register that holds byte lane k.
    function automatic logic [OFS_W-1:0] lane_offset(input int unsigned k);
        return OFS_W'(int'(RS_DLO) - int'(k));
    endfunction

endpackage

// File: rtl/hpb_decode.sv
module hpb_decode
    import hpb_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    output wr_strobe_t       wstb,
    output logic             rd_lo
);

    always_comb begin
        wstb.ctrl = wr && (addr == RS_CTRL);
        wstb.cvr  = wr && (addr == RS_CVR);
        wstb.ivr  = wr && (addr == RS_IVR);
    end

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        assign wstb.lane[g] = wr && (addr == lane_offset(g));
    end

    assign rd_lo = rd && (addr == RS_DLO);

endmodule

// File: rtl/hpb_cmd_unit.sv
module hpb_cmd_unit #(
    parameter int               VEC_W     = 7,
    parameter logic [VEC_W-1:0] VEC_RESET = 'h12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cvr,
    input  logic [7:0]       wdata,
    input  logic             ack,
    output logic             pend,
    output logic [VEC_W-1:0] vec,
    output logic [VEC_W:0]   exc_addr
);

    logic             pend_q;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            vec_q  <= VEC_RESET;
        end else if (pend_q) begin
            // Register frozen while a request is outstanding.
            if (ack) pend_q <= 1'b0;
        end else if (wr_cvr) begin
            vec_q  <= wdata[VEC_W-1:0];
            pend_q <= wdata[hpb_pkg::CVR_REQ_BIT];
        end
    end

    assign pend     = pend_q;
    assign vec      = vec_q;
    assign exc_addr = {vec_q, 1'b0};

endmodule

// File: rtl/hpb_h2c_path.sv
module hpb_h2c_path
    import hpb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [DATA_BYTES-1:0] wr_lane,
    input  logic [7:0]            wdata,
    input  logic                  take,
    output logic [WORD_W-1:0]     word,
    output logic                  valid
);

    logic [DATA_BYTES-1:0][7:0] stage_q;
    logic [WORD_W-1:0]          word_q;
    logic [WORD_W-1:0]          assembled;
    logic                       valid_q;
    logic                       commit;

    // Lane 0 is never staged: its write is the commit itself.
    assign stage_q[0] = 8'h00;

    for (genvar g = 1; g < DATA_BYTES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || flush)     stage_q[g] <= 8'h00;
            else if (wr_lane[g])  stage_q[g] <= wdata;
        end
    end

    always_comb begin
        assembled = stage_q;
        assembled[7:0] = wdata;
    end

    assign commit = wr_lane[0] && !valid_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (commit) begin
            word_q  <= assembled;
            valid_q <= 1'b1;
        end else if (take) begin
            valid_q <= 1'b0;
        end
    end

    assign word  = word_q;
    assign valid = valid_q;

endmodule

// File: rtl/hpb_c2h_path.sv
module hpb_c2h_path
    import hpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_lo,
    output logic [WORD_W-1:0] word,
    output logic              full
);

    logic [WORD_W-1:0] word_q;
    logic              full_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            word_q <= '0;
            full_q <= 1'b0;
        end else if (load && !full_q) begin
            word_q <= word_in;
            full_q <= 1'b1;
        end else if (rd_lo) begin
            full_q <= 1'b0;
        end
    end

    assign word = word_q;
    assign full = full_q;

endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
    import hpb_pkg::*;
#(
    parameter int               VEC_W     = 7,
    parameter logic [VEC_W-1:0] VEC_RESET = 'h12,
    parameter logic [7:0]       IVR_RESET = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [23:0]       core_rx_word,
    output logic              core_rx_valid,
    input  logic              core_rx_take,
    input  logic [23:0]       core_tx_word,
    input  logic              core_tx_load,
    output logic              core_tx_ready,
    output logic              cmd_req,
    output logic [VEC_W:0]    cmd_vector_addr,
    input  logic              cmd_ack
);

    wr_strobe_t        wstb;
    logic              rd_lo;
    logic              init_q;
    logic [7:0]        ivr_q;
    logic              cmd_pend;
    logic [VEC_W-1:0]  cmd_vec;
    logic [WORD_W-1:0] c2h_word;
    logic              c2h_full;
    logic              h2c_valid;
    status_t           stat;
    logic [7:0]        cvr_rd;

    hpb_decode u_decode (
        .addr  (host_addr),
        .wr    (host_wr),
        .rd    (host_rd),
        .wstb  (wstb),
        .rd_lo (rd_lo)
    );

    hpb_cmd_unit #(.VEC_W(VEC_W), .VEC_RESET(VEC_RESET)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_cvr   (wstb.cvr),
        .wdata    (host_wdata),
        .ack      (cmd_ack),
        .pend     (cmd_pend),
        .vec      (cmd_vec),
        .exc_addr (cmd_vector_addr)
    );

    hpb_h2c_path u_h2c (
        .clk     (clk),
        .rst     (rst),
        .flush   (init_q),
        .wr_lane (wstb.lane),
        .wdata   (host_wdata),
        .take    (core_rx_take),
        .word    (core_rx_word),
        .valid   (h2c_valid)
    );

    hpb_c2h_path u_c2h (
        .clk     (clk),
        .rst     (rst),
        .flush   (init_q),
        .load    (core_tx_load),
        .word_in (core_tx_word),
        .rd_lo   (rd_lo),
        .word    (c2h_word),
        .full    (c2h_full)
    );

    // Flush request: visible for one cycle, acted on at the following edge.
    always_ff @(posedge clk) begin
        if (rst)            init_q <= 1'b0;
        else if (init_q)    init_q <= 1'b0;
        else if (wstb.ctrl) init_q <= host_wdata[CTRL_FLUSH_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)           ivr_q <= IVR_RESET;
        else if (wstb.ivr) ivr_q <= host_wdata;
    end

    always_comb begin
        stat.cmd_busy = cmd_pend;
        stat.tx_empty = !h2c_valid;
        stat.rx_full  = c2h_full;
    end

    always_comb begin
        cvr_rd = '0;
        cvr_rd[VEC_W-1:0]   = cmd_vec;
        cvr_rd[CVR_REQ_BIT] = cmd_pend;
    end

    always_comb begin
        case (reg_sel_e'(host_addr))
            RS_CTRL: host_rdata = {init_q, 7'b0};
            RS_CVR:  host_rdata = cvr_rd;
            RS_STAT: host_rdata = status_byte(stat);
            RS_IVR:  host_rdata = ivr_q;
            RS_DHI:  host_rdata = lane_of(c2h_word, 2);
            RS_DMID: host_rdata = lane_of(c2h_word, 1);
            RS_DLO:  host_rdata = lane_of(c2h_word, 0);
            default: host_rdata = 8'h00;
        endcase
    end

    assign core_rx_valid = h2c_valid;
    assign core_tx_ready = !c2h_full;
    assign cmd_req       = cmd_pend;

endmodule

// File: rtl/hpb_checker.sv
module hpb_checker #(
    parameter int VEC_W = 7
) (
    input logic           clk,
    input logic           rst,
    input logic [2:0]     host_addr,
    input logic           host_wr,
    input logic           host_rd,
    input logic [7:0]     host_rdata,
    input logic [23:0]    core_rx_word,
    input logic           core_rx_valid,
    input logic           core_tx_load,
    input logic           core_tx_ready,
    input logic           cmd_req,
    input logic [VEC_W:0] cmd_vector_addr,
    input logic           cmd_ack,
    input logic           init_q
);

    a_r2_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 3'd4) |-> (host_rdata == 8'h00));

    a_r3_low_write_commits: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 3'd7 && !core_rx_valid && !init_q) |=> core_rx_valid);

    a_r4_full_word_held: assert property (@(posedge clk) disable iff (rst)
        (core_rx_valid && !init_q) |=> $stable(core_rx_word));

    a_r5_load_fills: assert property (@(posedge clk) disable iff (rst)
        (core_tx_load && core_tx_ready && !init_q) |=> !core_tx_ready);

    a_r6_low_read_drains: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 3'd7 && !init_q && !(core_tx_load && core_tx_ready))
        |=> core_tx_ready);

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
        cmd_req |=> $stable(cmd_vector_addr));

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> cmd_req);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_ack) |=> !cmd_req);

    a_r10_status_map: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 3'd2) |-> (host_rdata == {5'b0, cmd_req, !core_rx_valid, !core_tx_ready}));

    a_r11_flush_pulse: assert property (@(posedge clk) disable iff (rst)
        init_q |=> (!init_q && !core_rx_valid && core_tx_ready));

endmodule

bind hostport_bridge hpb_checker #(.VEC_W(VEC_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_addr       (host_addr),
    .host_wr         (host_wr),
    .host_rd         (host_rd),
    .host_rdata      (host_rdata),
    .core_rx_word    (core_rx_word),
    .core_rx_valid   (core_rx_valid),
    .core_tx_load    (core_tx_load),
    .core_tx_ready   (core_tx_ready),
    .cmd_req         (cmd_req),
    .cmd_vector_addr (cmd_vector_addr),
    .cmd_ack         (cmd_ack),
    .init_q          (init_q)
);

// File: tb/hostport_bridge_tb.sv
module hostport_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = 3'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [23:0] core_rx_word;
    logic        core_rx_valid;
    logic        core_rx_take = 1'b0;
    logic [23:0] core_tx_word = 24'h0;
    logic        core_tx_load = 1'b0;
    logic        core_tx_ready;
    logic        cmd_req;
    logic [7:0]  cmd_vector_addr;
    logic        cmd_ack = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    hostport_bridge u_dut (
        .clk             (clk),
        .rst             (rst),
        .host_addr       (host_addr),
        .host_wr         (host_wr),
        .host_rd         (host_rd),
        .host_wdata      (host_wdata),
        .host_rdata      (host_rdata),
        .core_rx_word    (core_rx_word),
        .core_rx_valid   (core_rx_valid),
        .core_rx_take    (core_rx_take),
        .core_tx_word    (core_tx_word),
        .core_tx_load    (core_tx_load),
        .core_tx_ready   (core_tx_ready),
        .cmd_req         (cmd_req),
        .cmd_vector_addr (cmd_vector_addr),
        .cmd_ack         (cmd_ack)
    );

    function automatic logic [7:0] exp_status(input logic busy, input logic txe, input logic rxf);
        return {5'b0, busy, txe, rxf};
    endfunction

    function automatic logic [7:0] exp_exc(input logic [6:0] v);
        return {v, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hpeek(input logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ctake();
        @(negedge clk); core_rx_take = 1'b1;
        @(negedge clk); core_rx_take = 1'b0;
    endtask

    task automatic cload(input logic [23:0] w);
        @(negedge clk); core_tx_word = w; core_tx_load = 1'b1;
        @(negedge clk); core_tx_load = 1'b0;
    endtask

    task automatic cack();
        @(negedge clk); cmd_ack = 1'b1;
        @(negedge clk); cmd_ack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  d;
        logic [7:0]  hi_m, mid_m;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hpeek(3'd2, d); check("R1 status", d, exp_status(0, 1, 0));
        hpeek(3'd1, d); check("R1 cvr", d, 8'h12);
        hpeek(3'd3, d); check("R1 ivr", d, 8'h0F);
        hpeek(3'd0, d); check("R1 ctrl", d, 8'h00);
        check("R1 outputs", {cmd_req, core_rx_valid, core_tx_ready}, 3'b001);

        // R2 unused offset
        hwrite(3'd4, 8'hFF);
        hpeek(3'd4, d); check("R2 unused read", d, 8'h00);
        hpeek(3'd2, d); check("R2 status untouched", d, exp_status(0, 1, 0));
        check("R2 outputs untouched", {cmd_req, core_rx_valid, core_tx_ready}, 3'b001);

        // R12 interrupt vector storage
        hwrite(3'd3, 8'hA5);
        hpeek(3'd3, d); check("R12 ivr", d, 8'hA5);

        // R3 commit
        hwrite(3'd5, 8'h12); hwrite(3'd6, 8'h34);
        check("R3 no commit before low", core_rx_valid, 1'b0);
        hwrite(3'd7, 8'h56);
        check("R3 valid", core_rx_valid, 1'b1);
        check("R3 word", core_rx_word, 24'h123456);
        hpeek(3'd2, d); check("R4 txe clear", d, exp_status(0, 0, 0));
        // R4 overrun dropped
        hwrite(3'd7, 8'h99);
        check("R4 full write dropped", core_rx_word, 24'h123456);
        ctake();
        check("R4 take clears valid", core_rx_valid, 1'b0);
        hpeek(3'd2, d); check("R4 txe set", d, exp_status(0, 1, 0));
        // R3 staged bytes kept
        hwrite(3'd7, 8'h77);
        check("R3 retained staging", core_rx_word, 24'h123477);
        ctake();

        // R5 / R6 core to host
        cload(24'hABCDEF);
        check("R5 ready low", core_tx_ready, 1'b0);
        hpeek(3'd2, d); check("R5 rxf", d, exp_status(0, 1, 1));
        cload(24'h111111);
        hread(3'd5, d); check("R6 high byte", d, 8'hAB);
        hread(3'd6, d); check("R6 mid byte", d, 8'hCD);
        check("R6 upper reads keep rxf", core_tx_ready, 1'b0);
        hread(3'd7, d); check("R5 full load ignored", d, 8'hEF);
        hpeek(3'd2, d); check("R6 low read clears rxf", d, exp_status(0, 1, 0));

        // R7 / R8 / R10 command
        hwrite(3'd1, 8'h92);
        check("R7 req", cmd_req, 1'b1);
        check("R7 addr", cmd_vector_addr, exp_exc(7'h12));
        hpeek(3'd2, d); check("R10 busy bit", d, exp_status(1, 1, 0));
        hwrite(3'd1, 8'h85);
        hpeek(3'd1, d); check("R8 write ignored while pending", d, 8'h92);
        repeat (3) @(negedge clk);
        check("R8 held", cmd_req, 1'b1);
        cack();
        check("R8 ack clears", cmd_req, 1'b0);
        hpeek(3'd1, d); check("R8 readback after ack", d, 8'h12);
        // R9 vector without request
        hwrite(3'd1, 8'h05);
        check("R9 no req", cmd_req, 1'b0);
        hpeek(3'd1, d); check("R9 vector", d, 8'h05);
        hwrite(3'd1, 8'hC5);
        check("R7 addr large vector", cmd_vector_addr, exp_exc(7'h45));

        // R11 flush, command left pending
        hwrite(3'd5, 8'hE1); hwrite(3'd6, 8'hE2); hwrite(3'd7, 8'hE3);
        cload(24'h5A5A5A);
        hwrite(3'd0, 8'h80);
        hpeek(3'd0, d); check("R11 ctrl pulse", d, 8'h80);
        @(negedge clk);
        hpeek(3'd0, d); check("R11 ctrl self clear", d, 8'h00);
        check("R11 rx flushed", {core_rx_valid, core_rx_word}, 25'h0);
        check("R11 tx ready", core_tx_ready, 1'b1);
        hpeek(3'd5, d); check("R11 c2h zeroed", d, 8'h00);
        check("R11 cmd untouched", cmd_req, 1'b1);
        hwrite(3'd7, 8'h3C);
        check("R11 staging cleared", core_rx_word, 24'h00003C);
        ctake(); cack();

        // Randomised traffic
        hi_m = 8'h00; mid_m = 8'h00;
        for (int i = 0; i < 30; i++) begin
            logic [31:0] r;
            logic [7:0]  lo;
            logic [23:0] cw;
            r = $urandom;
            if (r[0]) begin hi_m = r[15:8]; hwrite(3'd5, hi_m); end
            if (r[1]) begin mid_m = r[23:16]; hwrite(3'd6, mid_m); end
            lo = r[31:24];
            hwrite(3'd7, lo);
            check("R3 random word", core_rx_word, {hi_m, mid_m, lo});
            ctake();
            cw = 24'($urandom);
            cload(cw);
            hread(3'd5, d); check("R6 random high", d, cw[23:16]);
            hread(3'd6, d); check("R6 random mid", d, cw[15:8]);
            hread(3'd7, d); check("R6 random low", d, cw[7:0]);
            hpeek(3'd2, d); check("R10 random status", d, exp_status(0, 1, 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule